// File: doc/BRIEF.md
# Encoded Programmable Clock Divider

This block divides one of two source clocks by a ratio taken from a compact, non-binary divider code. Both sources are modelled as clock-enable pulses on one system clock: a fixed 288 MHz source and an alternate source whose frequency is one of four values chosen by a 2-bit strap. The divider code is a 3-bit power-of-two shift combined with an odd prescale of 1 or 3. A wider variant of the code also offers a prescale of 5. So the reachable ratios are 2^n, 3·2^n and, in the wide form, 5·2^n for n from 0 to 7. One further code bit picks the source.

A new code is written with a one-cycle strobe. It is parked in a pending register and is applied only when the divided period in progress completes. The output enable therefore never produces a runt period, and the source changes without a glitch. The active ratio is reported as a plain integer. The frequency in MHz of the active source is also reported. A code that combines both odd prescalers is reserved: it is refused, and it raises an error flag.

Top module: `encdiv_clkgen`

## Requirements
- R1: After reset the active ratio is 1, the fixed source is selected, `code_err` is low and `src_mhz` is 288. With a source tick every cycle, `div_tick` is then high on every cycle.
- R2: Code bits [2:0] hold a shift n from 0 to 7. With both prescale bits clear, the ratio is 2^n.
- R3: When code bit 3 is set, a prescale of 3 applies and the ratio is 3·2^n. Codes 8 to 15 give 3, 6, 12, 24, 48, 96, 192 and 384.
- R4: With WIDE=1 the code is 6 bits wide. Bit 4 set selects a prescale of 5, so codes 16 to 23 give 5·2^n. With WIDE=0 there is no prescale of 5.
- R5: With WIDE=1, a write in which bits 3 and 4 are both set (codes 24 to 31) is reserved. Such a write leaves the active and pending ratios unchanged and sets `code_err` on the next cycle. Any valid write clears `code_err`.
- R6: The top code bit selects the source: bit 5 when WIDE=1, bit 4 when WIDE=0. Value 0 counts `fix_tick` and value 1 counts `alt_tick`. The active source is shown on `src_alt`.
- R7: `src_mhz` is 288 while the fixed source is active. While the alternate source is active it follows `alt_sel`: 00 gives 336, 01 gives 288, 10 gives 240 and 11 gives 192.
- R8: `div_tick` is a single-cycle pulse. It is high on the cycle after every ratio-th tick of the active source, so with periodic ticks of spacing g the interval between pulses is ratio·g cycles.
- R9: A valid write takes effect only at the end of the period in progress. That period completes at the old ratio. `ratio` and `src_alt` change only on a cycle where `div_tick` is high. A write in the same cycle as a completing tick is applied at the following boundary.
- R10: When several valid writes arrive within one period, the last one is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_tick | input | 1 | Enable pulse of the fixed 288 MHz source |
| alt_tick | input | 1 | Enable pulse of the alternate source |
| alt_sel | input | 2 | Alternate source frequency strap |
| cfg_we | input | 1 | Write strobe for a new divider code |
| cfg_code | input | CODE_W (6 or 5) | Divider code: shift, prescale bit(s), source bit |
| div_tick | output | 1 | Divided clock-enable pulse |
| ratio | output | RATIO_W (10) | Active division ratio as an integer |
| src_alt | output | 1 | Active source is the alternate one |
| src_mhz | output | 9 | Frequency in MHz of the active source |
| code_err | output | 1 | Last write carried a reserved code |

## Verification
Every legal code of both variants is swept on the fixed source, which ticks every cycle. For each code the bench checks that the reported ratio equals prescale times 2^n and that the pulse interval equals that ratio. This separates the shift field from the two prescale bits, and it shows that bit 4 acts as a source select in the narrow form but as a prescale in the wide form. The alternate source ticks once every three cycles, so a tripled interval proves that only the selected source's ticks are counted. Separate patterns cover the remaining rules. A mid-period write must leave the running 96-cycle period intact. Two writes within one period must apply only the second. The reserved codes must set the flag and leave the ratio unchanged. A sweep of the alternate frequency strap checks the reported source frequency.

// File: rtl/encdiv_pkg.sv
// Package: shared constants and helpers for the encoded clock divider.
// Assumes a shift field of SHIFT_W bits and odd prescalers of at most 5.
package encdiv_pkg;

    // Largest odd prescaler any variant offers.
    localparam int PRE_MAX = 5;

    // Frequency field width and the fixed source frequency in MHz.
    localparam int MHZ_W = 9;
    localparam logic [MHZ_W-1:0] FIXED_MHZ = 9'd288;

    // Alternate source frequency strap encodings.
    typedef enum logic [1:0] {
        ALT_336 = 2'b00,
        ALT_288 = 2'b01,
        ALT_240 = 2'b10,
        ALT_192 = 2'b11
    } alt_freq_e;

    // Width needed to hold the largest ratio, PRE_MAX << (2^SHIFT_W - 1).
    function automatic int ratio_bits(input int shift_w);
        return $clog2((PRE_MAX << ((1 << shift_w) - 1)) + 1);
    endfunction

    // Frequency in MHz of the alternate source for a strap value.
    function automatic logic [MHZ_W-1:0] alt_mhz(input logic [1:0] sel);
        logic [MHZ_W-1:0] f;
        case (alt_freq_e'(sel))
            ALT_336: f = 9'd336;
            ALT_288: f = 9'd288;
            ALT_240: f = 9'd240;
            default: f = 9'd192;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/encdiv_decode.sv
// Module: encdiv_decode
// Turns a divider code into an integer ratio, a source select and a
// validity flag. The code layout is: shift in [SHIFT_W-1:0], the
// prescale-3 bit at SHIFT_W, and (when WIDE) the prescale-5 bit at
// SHIFT_W+1. The source select is always the top bit.
// Assumes: purely combinational; the caller registers the result.
module encdiv_decode #(
    parameter int SHIFT_W = 3,
    parameter bit WIDE    = 1'b1,
    parameter int CODE_W  = SHIFT_W + (WIDE ? 3 : 2),
    parameter int RATIO_W = encdiv_pkg::ratio_bits(SHIFT_W)
) (
    input  logic [CODE_W-1:0]  code,
    output logic [RATIO_W-1:0] ratio,
    output logic               sel_alt,
    output logic               valid
);

    logic       pre3;
    logic       pre5;
    logic [2:0] pre_val;

    assign pre3    = code[SHIFT_W];
    assign sel_alt = code[CODE_W-1];

    // The prescale-5 bit exists only in the wide variant.
    generate
        if (WIDE) begin : g_wide
            assign pre5 = code[SHIFT_W+1];
        end else begin : g_narrow
            assign pre5 = 1'b0;
        end
    endgenerate

    // Choose the odd prescaler; both bits together is reserved.
    always_comb begin
        valid   = !(pre3 && pre5);
        pre_val = 3'd1;
        if (pre5)
            pre_val = 3'd5;
        else if (pre3)
            pre_val = 3'd3;
    end

    assign ratio = RATIO_W'(pre_val) << code[SHIFT_W-1:0];

endmodule

// File: rtl/encdiv_shadow.sv
// Module: encdiv_shadow
// Holds the pending and the active divider settings. A valid write
// loads the pending copy, and the last write wins. The active copy
// is replaced from the pending copy only on a period boundary. A
// reserved write sets the error flag and changes no setting.
// Assumes: boundary is high for exactly the cycle whose tick ends a period.
module encdiv_shadow #(
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_valid,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic               wr_alt,
    input  logic               boundary,
    output logic [RATIO_W-1:0] act_ratio,
    output logic               act_alt,
    output logic               code_err
);

    logic               pend_v;
    logic [RATIO_W-1:0] pend_ratio;
    logic               pend_alt;

    // Pending copy: capture valid writes, drop the flag once applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_ratio <= RATIO_W'(1);
            pend_alt   <= 1'b0;
        end else if (wr_en && wr_valid) begin
            pend_v     <= 1'b1;
            pend_ratio <= wr_ratio;
            pend_alt   <= wr_alt;
        end else if (boundary) begin
            pend_v     <= 1'b0;
        end
    end

    // Active copy: swap in the pending setting at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ratio <= RATIO_W'(1);
            act_alt   <= 1'b0;
        end else if (boundary && pend_v) begin
            act_ratio <= pend_ratio;
            act_alt   <= pend_alt;
        end
    end

    // Error flag: reflects whether the most recent write was reserved.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_err <= 1'b0;
        else if (wr_en)
            code_err <= !wr_valid;
    end

endmodule

// File: rtl/encdiv_count.sv
// Module: encdiv_count
// Counts ticks of the selected source and raises a one-cycle enable
// after every ratio-th tick. It also reports the boundary cycle
// (the tick that completes a period) so that a new setting can be
// swapped in without a runt period.
// Assumes: ratio is at least 1 and changes only on a boundary.
module encdiv_count #(
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fix_tick,
    input  logic               alt_tick,
    input  logic               sel_alt,
    input  logic [RATIO_W-1:0] ratio,
    output logic               boundary,
    output logic               div_tick
);

    logic [RATIO_W-1:0] cnt;
    logic               src_tick;

    // Only the active source's ticks advance the count.
    assign src_tick = sel_alt ? alt_tick : fix_tick;
    assign boundary = src_tick && (cnt >= ratio - RATIO_W'(1));

    // Period counter: restart on the completing tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (boundary)
            cnt <= '0;
        else if (src_tick)
            cnt <= cnt + RATIO_W'(1);
    end

    // Output enable: registered pulse on the cycle after the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_tick <= 1'b0;
        else
            div_tick <= boundary;
    end

endmodule

// File: rtl/encdiv_clkgen.sv
// Module: encdiv_clkgen (top)
// Encoded programmable clock divider. It decodes the written code,
// keeps it pending until the running period ends, then divides the
// selected source's tick train by the active ratio. It reports the
// ratio and the active source frequency.
// Assumes: both sources arrive as enables synchronous to clk.
module encdiv_clkgen #(
    parameter int SHIFT_W  = 3,
    parameter bit WIDE     = 1'b1,
    localparam int CODE_W  = SHIFT_W + (WIDE ? 3 : 2),
    localparam int RATIO_W = encdiv_pkg::ratio_bits(SHIFT_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fix_tick,
    input  logic                          alt_tick,
    input  logic [1:0]                    alt_sel,
    input  logic                          cfg_we,
    input  logic [CODE_W-1:0]             cfg_code,
    output logic                          div_tick,
    output logic [RATIO_W-1:0]            ratio,
    output logic                          src_alt,
    output logic [encdiv_pkg::MHZ_W-1:0]  src_mhz,
    output logic                          code_err
);

    logic [RATIO_W-1:0] dec_ratio;
    logic               dec_alt;
    logic               dec_valid;
    logic               boundary;

    encdiv_decode #(
        .SHIFT_W (SHIFT_W),
        .WIDE    (WIDE),
        .CODE_W  (CODE_W),
        .RATIO_W (RATIO_W)
    ) u_decode (
        .code    (cfg_code),
        .ratio   (dec_ratio),
        .sel_alt (dec_alt),
        .valid   (dec_valid)
    );

    encdiv_shadow #(
        .RATIO_W (RATIO_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_valid  (dec_valid),
        .wr_ratio  (dec_ratio),
        .wr_alt    (dec_alt),
        .boundary  (boundary),
        .act_ratio (ratio),
        .act_alt   (src_alt),
        .code_err  (code_err)
    );

    encdiv_count #(
        .RATIO_W (RATIO_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .fix_tick (fix_tick),
        .alt_tick (alt_tick),
        .sel_alt  (src_alt),
        .ratio    (ratio),
        .boundary (boundary),
        .div_tick (div_tick)
    );

    // Active source frequency for reporting.
    always_comb begin
        src_mhz = src_alt ? encdiv_pkg::alt_mhz(alt_sel) : encdiv_pkg::FIXED_MHZ;
    end

endmodule

// File: rtl/encdiv_clkgen_chk.sv
// Module: encdiv_clkgen_chk
// Checker for encdiv_clkgen, attached to every instance by bind.
// It watches only the top-level ports.
module encdiv_clkgen_chk #(
    parameter int SHIFT_W  = 3,
    parameter bit WIDE     = 1'b1,
    parameter int CODE_W   = SHIFT_W + (WIDE ? 3 : 2),
    parameter int RATIO_W  = encdiv_pkg::ratio_bits(SHIFT_W)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          fix_tick,
    input logic                          alt_tick,
    input logic                          cfg_we,
    input logic [CODE_W-1:0]             cfg_code,
    input logic                          div_tick,
    input logic [RATIO_W-1:0]            ratio,
    input logic                          src_alt,
    input logic [encdiv_pkg::MHZ_W-1:0]  src_mhz,
    input logic                          code_err
);

    logic reserved_wr;
    assign reserved_wr = cfg_we && cfg_code[SHIFT_W] && WIDE && cfg_code[SHIFT_W+1];

    // A ratio is legal when it is an odd prescale times 2^n, n < 2^SHIFT_W.
    function automatic bit legal_ratio(input logic [RATIO_W-1:0] r);
        logic [RATIO_W-1:0] v;
        v = r;
        for (int i = 0; i < (1 << SHIFT_W) - 1; i++)
            if (v != '0 && !v[0])
                v = v >> 1;
        return (v == RATIO_W'(1)) || (v == RATIO_W'(3)) || (WIDE && v == RATIO_W'(5));
    endfunction

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ratio == RATIO_W'(1) && !code_err && !src_alt)); // R1

    AST_LEGAL_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        legal_ratio(ratio)); // R4

    AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_wr |=> (code_err && $stable(ratio))); // R5

    AST_VALID_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !reserved_wr) |=> !code_err); // R5

    AST_FIXED_MHZ: assert property (@(posedge clk) disable iff (!rst_n)
        !src_alt |-> (src_mhz == encdiv_pkg::FIXED_MHZ)); // R7

    AST_TICK_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> $past(src_alt ? alt_tick : fix_tick)); // R8

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && ratio != RATIO_W'(1)) |=> !div_tick); // R8

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != $past(ratio)) |-> div_tick); // R9

    AST_SRC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_alt != $past(src_alt)) |-> div_tick); // R9

endmodule

bind encdiv_clkgen encdiv_clkgen_chk #(
    .SHIFT_W (SHIFT_W),
    .WIDE    (WIDE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fix_tick (fix_tick),
    .alt_tick (alt_tick),
    .cfg_we   (cfg_we),
    .cfg_code (cfg_code),
    .div_tick (div_tick),
    .ratio    (ratio),
    .src_alt  (src_alt),
    .src_mhz  (src_mhz),
    .code_err (code_err)
);

// File: tb/encdiv_clkgen_tb.sv
// Bench: sweeps every legal code of a wide and a narrow instance and
// checks ratios, pulse intervals, boundary switching and error handling.
module encdiv_clkgen_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       fix_tick = 1'b1;
    logic       alt_tick;
    logic [1:0] alt_sel = 2'b00;
    int         acnt = 0;

    // Alternate source ticks once every three cycles.
    always @(negedge clk) acnt <= (acnt == 2) ? 0 : acnt + 1;
    assign alt_tick = (acnt == 0);

    logic       we_w = 1'b0, we_n = 1'b0;
    logic [5:0] code_w = '0;
    logic [4:0] code_n = '0;
    logic       tick_w, tick_n, alt_w, alt_n, err_w, err_n;
    logic [9:0] ratio_w, ratio_n;
    logic [8:0] mhz_w, mhz_n;

    encdiv_clkgen #(.SHIFT_W(3), .WIDE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .alt_tick(alt_tick),
        .alt_sel(alt_sel), .cfg_we(we_w), .cfg_code(code_w), .div_tick(tick_w),
        .ratio(ratio_w), .src_alt(alt_w), .src_mhz(mhz_w), .code_err(err_w));

    encdiv_clkgen #(.SHIFT_W(3), .WIDE(1'b0)) u_dut_n (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .alt_tick(alt_tick),
        .alt_sel(alt_sel), .cfg_we(we_n), .cfg_code(code_n), .div_tick(tick_n),
        .ratio(ratio_n), .src_alt(alt_n), .src_mhz(mhz_n), .code_err(err_n));

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_ratio(input int code, input bit wide);
        int pre;
        pre = (wide && code[4]) ? 5 : (code[3] ? 3 : 1);
        return pre << (code & 7);
    endfunction

    function automatic int cur_ratio(input bit wide);
        return wide ? int'(ratio_w) : int'(ratio_n);
    endfunction

    function automatic bit cur_tick(input bit wide);
        return wide ? tick_w : tick_n;
    endfunction

    task automatic wr(input bit wide, input int code);
        @(negedge clk);
        if (wide) begin we_w = 1'b1; code_w = code[5:0]; end
        else      begin we_n = 1'b1; code_n = code[4:0]; end
        @(negedge clk);
        we_w = 1'b0;
        we_n = 1'b0;
    endtask

    task automatic wait_ratio(input bit wide, input int exp);
        for (int i = 0; i < 3000; i++) begin
            if (cur_ratio(wide) == exp) break;
            @(negedge clk);
        end
    endtask

    // Waits for a pulse, then returns the cycles to the next pulse.
    task automatic interval(input bit wide, output int n);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (cur_tick(wide)) break;
        end
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            n++;
            if (cur_tick(wide)) break;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int e;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on both instances.
        check(ratio_w == 10'd1, "R1", "reset ratio", int'(ratio_w), 1);
        check(!err_w && !alt_w, "R1", "reset err/src", int'({err_w, alt_w}), 0);
        check(mhz_w == 9'd288, "R1", "reset mhz", int'(mhz_w), 288);
        check(ratio_n == 10'd1, "R1", "narrow reset ratio", int'(ratio_n), 1);
        interval(1'b1, n);
        check(n == 1, "R1", "reset interval", n, 1);

        // R2 R3 R4 R8: wide sweep of all legal codes on the fixed source.
        for (int c = 0; c < 24; c++) begin
            e = exp_ratio(c, 1'b1);
            wr(1'b1, c);
            wait_ratio(1'b1, e);
            check(cur_ratio(1'b1) == e, c < 8 ? "R2" : (c < 16 ? "R3" : "R4"),
                  $sformatf("wide code %0d ratio", c), cur_ratio(1'b1), e);
            interval(1'b1, n);
            check(n == e, "R8", $sformatf("wide code %0d interval", c), n, e);
        end

        // R2 R3: narrow sweep of all codes on the fixed source.
        for (int c = 0; c < 16; c++) begin
            e = exp_ratio(c, 1'b0);
            wr(1'b0, c);
            wait_ratio(1'b0, e);
            check(cur_ratio(1'b0) == e, c < 8 ? "R2" : "R3",
                  $sformatf("narrow code %0d ratio", c), cur_ratio(1'b0), e);
            interval(1'b0, n);
            check(n == e, "R8", $sformatf("narrow code %0d interval", c), n, e);
        end

        // R6 R4: narrow bit 4 is the source select, not a prescale of 5.
        wr(1'b0, 16 | 8);
        wait_ratio(1'b0, 3);
        check(ratio_n == 10'd3 && alt_n, "R6", "narrow alt ratio", int'(ratio_n), 3);
        interval(1'b0, n);
        check(n == 9, "R6", "narrow alt interval", n, 9);

        // R9: a mid-period write does not cut the running period.
        wr(1'b1, 13);
        wait_ratio(1'b1, 96);
        interval(1'b1, n);
        n = 0;
        repeat (10) begin @(negedge clk); n++; end
        we_w = 1'b1; code_w = 6'd8;
        @(negedge clk); n++;
        we_w = 1'b0;
        check(ratio_w == 10'd96, "R9", "ratio held mid-period", int'(ratio_w), 96);
        for (int i = 0; i < 500; i++) begin
            if (tick_w) break;
            @(negedge clk); n++;
        end
        check(n == 96, "R9", "old period completes", n, 96);
        check(ratio_w == 10'd3, "R9", "new ratio at boundary", int'(ratio_w), 3);
        interval(1'b1, n);
        check(n == 3, "R9", "new period", n, 3);

        // R10: last of several writes within one period wins.
        wr(1'b1, 15);
        wait_ratio(1'b1, 384);
        interval(1'b1, n);
        wr(1'b1, 1);
        wr(1'b1, 2);
        wait_ratio(1'b1, 4);
        wait_ratio(1'b1, 2);
        check(ratio_w == 10'd4, "R10", "last write applied", int'(ratio_w), 4);

        // R5: reserved codes set the flag and leave the ratio alone.
        for (int c = 24; c < 32; c++) begin
            wr(1'b1, c);
            check(err_w == 1'b1, "R5", $sformatf("reserved %0d flag", c), int'(err_w), 1);
            repeat (20) @(negedge clk);
            check(ratio_w == 10'd4, "R5", $sformatf("reserved %0d ratio", c), int'(ratio_w), 4);
        end
        interval(1'b1, n);
        check(n == 4, "R5", "interval after reserved", n, 4);
        wr(1'b1, 1);
        check(err_w == 1'b0, "R5", "valid write clears flag", int'(err_w), 0);

        // R6 R7: alternate source select, intervals and frequencies.
        wr(1'b1, 32 | 0);
        wait_ratio(1'b1, 1);
        check(alt_w == 1'b1, "R6", "alt selected", int'(alt_w), 1);
        interval(1'b1, n);
        check(n == 3, "R6", "alt ratio 1 interval", n, 3);
        wr(1'b1, 32 | 9);
        wait_ratio(1'b1, 6);
        interval(1'b1, n);
        check(n == 18, "R6", "alt ratio 6 interval", n, 18);
        wr(1'b1, 32 | 18);
        wait_ratio(1'b1, 20);
        interval(1'b1, n);
        check(n == 60, "R6", "alt ratio 20 interval", n, 60);
        for (int s = 0; s < 4; s++) begin
            alt_sel = s[1:0];
            @(negedge clk);
            e = (s == 0) ? 336 : (s == 1) ? 288 : (s == 2) ? 240 : 192;
            check(int'(mhz_w) == e, "R7", $sformatf("alt_sel %0d mhz", s), int'(mhz_w), e);
        end
        wr(1'b1, 0);
        wait_ratio(1'b1, 1);
        check(!alt_w && mhz_w == 9'd288, "R7", "fixed mhz again", int'(mhz_w), 288);

        finish_run();
    end

endmodule